// File: doc/BRIEF.md
# Software store command sequence detector

This block sits beside a static memory's access port and watches the chip-enable, output-enable and write-enable strobes together with the address bus. It looks for a fixed, ordered key of six read accesses. When the sixth key read arrives, it sends a one-cycle request to the nonvolatile store controller. It then holds the memory interface disabled until that controller reports that the store has finished.

An access is counted once, on the clock cycle in which chip-enable is first sampled low after having been sampled high. The address and the two other strobes are sampled in that same cycle. Only a read counts as a key step, meaning output-enable low and write-enable high. A write, a read with output-enable inactive, or a read at the wrong address cancels the partial match. There is one exception: a read at the first key address starts a new attempt at step one. The request does not depend on any earlier write history; whenever the key is seen, a store is requested.

Top module: `swst_seq_detect`

## Requirements
- R1: Six counted read accesses at addresses 0x04E38, 0x0B1C7, 0x083E0, 0x07C1F, 0x0703F, 0x08FC0, in that order, raise `store_req` for exactly one cycle. The pulse is visible after the clock edge that samples the sixth chip-enable fall.
- R2: An access counts as a key step only if, in the cycle of the chip-enable fall, `oe_n` is 0 and `we_n` is 1.
- R3: A write access (`we_n` = 0 at the chip-enable fall) at any step cancels the partial match, so the key steps that follow it produce no request.
- R4: A read with `oe_n` = 1 at the chip-enable fall cancels the partial match, even at the correct key address.
- R5: A counted read at an address other than the expected key address cancels the partial match.
- R6: A counted read at the first key address that does not continue the match restarts it at step one. The five remaining key reads then complete the key.
- R7: `chip_off` rises in the same cycle as `store_req`. It stays high until `store_done` is sampled high, and is low after that edge.
- R8: While `chip_off` is high, chip-enable falls are ignored, and the match is left at idle. After completion, a partial key (steps two to six) gives no request.
- R9: A chip-enable held low for several cycles counts as one access at the address sampled in its first low cycle. Address changes while it stays low have no effect.
- R10: During and right after reset, `store_req` and `chip_off` are 0 and the match is idle.
- R11: `store_done` has no effect while `chip_off` is low.
- R12: All 17 address bits are compared. A key pattern with bit 16 set cancels the match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 17 | Access address |
| store_done | input | 1 | Store controller reports completion |
| store_req | output | 1 | One-cycle store request |
| chip_off | output | 1 | Memory interface disabled while store runs |

## Verification
A wrong step index shows up at the ports as a missing `store_req` after a valid key, or as a spurious `store_req` after a cancelled key. Either way it appears one clock edge after the final chip-enable fall of the sequence, so every access is followed by a compare in the next low clock phase. A busy flag that does not clear, or clears too early, shows on `chip_off` immediately after the `store_done` edge. It also shows in how the next key is accepted. The bench therefore checks `chip_off` after every access and every completion pulse.

// File: rtl/swst_pkg.sv
package swst_pkg;

    localparam int KEY_W     = 17;
    localparam int KEY_STEPS = 6;

    // Ordered unlock key; position in the list is the step number.
    function automatic logic [KEY_W-1:0] key_at(input int unsigned idx);
        logic [KEY_W-1:0] k;
        case (idx)
            0:       k = 17'h04E38;
            1:       k = 17'h0B1C7;
            2:       k = 17'h083E0;
            3:       k = 17'h07C1F;
            4:       k = 17'h0703F;
            5:       k = 17'h08FC0;
            default: k = '0;
        endcase
        return k;
    endfunction

    typedef struct packed {
        logic ce_prev;
    } samp_state_t;

    typedef struct packed {
        logic busy;
        logic req;
    } ctl_state_t;

endpackage

// File: rtl/swst_access_sampler.sv
module swst_access_sampler
    import swst_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic acc_strobe,
    output logic acc_is_read
);

    samp_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.ce_prev = ce_n;
        // one access per high-to-low transition of chip enable
        acc_strobe   = st_q.ce_prev & ~ce_n;
        acc_is_read  = ~oe_n & we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ce_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/swst_step_matcher.sv
module swst_step_matcher
    import swst_pkg::*;
#(
    parameter  int ADDR_W    = 17,
    parameter  int NUM_STEPS = KEY_STEPS,
    localparam int IDX_W     = $clog2(NUM_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              strobe,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_STEPS - 1);

    logic [IDX_W-1:0] step_d, step_q;
    logic             step_ok;
    logic             first_ok;

    always_comb begin
        step_d   = step_q;
        hit      = 1'b0;
        step_ok  = is_read && (addr == ADDR_W'(key_at(int'(step_q))));
        first_ok = is_read && (addr == ADDR_W'(key_at(0)));
        if (clear) begin
            step_d = '0;
        end else if (strobe) begin
            if (step_ok) begin
                if (step_q == LAST_IDX) begin
                    hit    = 1'b1;
                    step_d = '0;
                end else begin
                    step_d = step_q + 1'b1;
                end
            end else if (first_ok) begin
                step_d = IDX_W'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= '0;
        end else begin
            step_q <= step_d;
        end
    end

endmodule

// File: rtl/swst_seq_detect.sv
module swst_seq_detect
    import swst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              store_done,
    output logic              store_req,
    output logic              chip_off
);

    ctl_state_t ctl_d, ctl_q;
    logic       acc_strobe;
    logic       acc_is_read;
    logic       key_hit;

    swst_access_sampler u_samp (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .acc_strobe (acc_strobe),
        .acc_is_read(acc_is_read)
    );

    swst_step_matcher #(
        .ADDR_W   (ADDR_W),
        .NUM_STEPS(KEY_STEPS)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctl_q.busy),
        .strobe (acc_strobe & ~ctl_q.busy),
        .is_read(acc_is_read),
        .addr   (addr),
        .hit    (key_hit)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.req = 1'b0;
        if (ctl_q.busy) begin
            if (store_done) begin
                ctl_d.busy = 1'b0;
            end
        end else if (key_hit) begin
            ctl_d.req  = 1'b1;
            ctl_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign store_req = ctl_q.req;
    assign chip_off  = ctl_q.busy;

endmodule

// File: rtl/swst_seq_detect_chk.sv
module swst_seq_detect_chk #(
    parameter int ADDR_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic [ADDR_W-1:0] addr,
    input logic              store_done,
    input logic              store_req,
    input logic              chip_off
);

    logic ce_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ce_seen_q <= 1'b1;
        else        ce_seen_q <= ce_n;
    end

    // R1
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req);

    // R7
    req_sets_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> chip_off);

    // R7
    off_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_off && !store_done) |=> chip_off);

    // R7
    off_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_off && store_done) |=> !chip_off);

    // R11
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chip_off && !(ce_seen_q && !ce_n)) |=> !chip_off);

    // R3
    write_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_seen_q && !ce_n && !we_n) |=> !store_req);

    // R9
    no_edge_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce_seen_q && !ce_n) |=> !store_req);

    // R8
    busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chip_off |=> !store_req);

endmodule

bind swst_seq_detect swst_seq_detect_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .oe_n      (oe_n),
    .we_n      (we_n),
    .addr      (addr),
    .store_done(store_done),
    .store_req (store_req),
    .chip_off  (chip_off)
);

// File: tb/tb_swst_seq_detect.sv
`timescale 1ns/1ps
module tb_swst_seq_detect;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic        we_n = 1'b1;
    logic [16:0] addr = '0;
    logic        store_done = 1'b0;
    logic        store_req;
    logic        chip_off;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;

    int m_idx  = 0;
    bit m_busy = 0;

    always #4 clk = ~clk;

    swst_seq_detect dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .we_n      (we_n),
        .addr      (addr),
        .store_done(store_done),
        .store_req (store_req),
        .chip_off  (chip_off)
    );

    function automatic logic [16:0] bkey(input int i);
        case (i)
            0: return 17'h04E38;
            1: return 17'h0B1C7;
            2: return 17'h083E0;
            3: return 17'h07C1F;
            4: return 17'h0703F;
            default: return 17'h08FC0;
        endcase
    endfunction

    // Reference step: returns expected request, updates model.
    function automatic bit model_step(input logic [16:0] a, input logic o, input logic w);
        bit rd;
        bit req;
        rd  = (o == 1'b0) && (w == 1'b1);
        req = 0;
        if (!m_busy) begin
            if (rd && a == bkey(m_idx)) begin
                if (m_idx == 5) begin
                    req = 1; m_busy = 1; m_idx = 0;
                end else begin
                    m_idx++;
                end
            end else if (rd && a == bkey(0)) begin
                m_idx = 1;
            end else begin
                m_idx = 0;
            end
        end
        return req;
    endfunction

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0b expected=%0b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic access(input logic [16:0] a, input logic o, input logic w,
                          input string tag, input int hold = 1);
        bit er;
        @(negedge clk);
        ce_n = 1'b0; addr = a; oe_n = o; we_n = w;
        er = model_step(a, o, w);
        @(negedge clk);
        chk(tag, "store_req", store_req, er);
        chk(tag, "chip_off", chip_off, m_busy);
        for (int h = 1; h < hold; h++) begin
            addr = $urandom; oe_n = $urandom; we_n = $urandom;
            @(negedge clk);
            chk(tag, "store_req(held)", store_req, 1'b0);
        end
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        chk(tag, "store_req(after)", store_req, 1'b0);
    endtask

    task automatic keys(input int first, input int last, input string tag);
        for (int k = first; k <= last; k++) access(bkey(k), 1'b0, 1'b1, tag);
    endtask

    task automatic done_pulse(input string tag);
        @(negedge clk);
        store_done = 1'b1;
        @(negedge clk);
        store_done = 1'b0;
        m_busy = 0;
        chk(tag, "chip_off", chip_off, 1'b0);
        chk(tag, "store_req", store_req, 1'b0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        chk("R10", "store_req in reset", store_req, 1'b0);
        chk("R10", "chip_off in reset", chip_off, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "store_req after reset", store_req, 1'b0);
        chk("R10", "chip_off after reset", chip_off, 1'b0);

        // R1 full key, R7 hold
        keys(0, 5, "R1");
        repeat (4) begin
            @(negedge clk);
            chk("R7", "chip_off held", chip_off, 1'b1);
        end
        // R8 key during busy ignored
        keys(0, 5, "R8");
        done_pulse("R7");
        keys(1, 5, "R8");
        keys(0, 5, "R2");
        done_pulse("R7");

        // R11 done while idle
        done_pulse("R11");
        keys(0, 2, "R11");
        done_pulse("R11");
        keys(3, 5, "R11");
        // match was kept across the idle done pulse, so the key completed
        done_pulse("R11");

        // R3 write aborts
        keys(0, 2, "R3");
        access(bkey(3), 1'b0, 1'b0, "R3");
        keys(3, 5, "R3");
        // R4 oe inactive aborts
        keys(0, 3, "R4");
        access(bkey(4), 1'b1, 1'b1, "R4");
        keys(4, 5, "R4");
        // R5 wrong address aborts
        keys(0, 4, "R5");
        access(17'h01234, 1'b0, 1'b1, "R5");
        access(bkey(5), 1'b0, 1'b1, "R5");
        // R6 restart on first key
        keys(0, 2, "R6");
        access(bkey(0), 1'b0, 1'b1, "R6");
        keys(1, 5, "R6");
        done_pulse("R6");
        // R9 long chip-enable low counts once
        for (int k = 0; k < 6; k++) access(bkey(k), 1'b0, 1'b1, "R9", 4);
        done_pulse("R9");
        // R12 bit 16 compared
        keys(0, 1, "R12");
        access(bkey(2) | 17'h10000, 1'b0, 1'b1, "R12");
        keys(3, 5, "R12");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int r;
            logic [16:0] a;
            r = $urandom_range(0, 99);
            if (m_busy && r < 15) begin
                done_pulse("R7");
            end else begin
                if (r < 70)      a = bkey(m_idx);
                else if (r < 80) a = bkey(0);
                else             a = 17'($urandom);
                access(a, ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) != 0), "R1");
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule